// File: doc/BRIEF.md
# ECC Error Logging Register Block

This block sits beside a memory datapath's ECC decoder and turns its error events into registers that software can read. The decoder raises a correctable-error (CE) strobe or an uncorrectable-error (UE) strobe for one cycle. Each strobe comes with the failing block address, an 8-bit syndrome and a one-bit channel number. The block keeps one sticky flag per error class and a single log slot holding the details of one error. It also holds an enable per class that drives a system-error output.

The log slot follows a priority rule. A CE fills the slot only when nothing is logged. A UE fills it whenever no UE is already logged, so a UE replaces the details of a pending CE, and the CE flag stays set. Software reads the registers over a simple bus, with no wait states and the read data combinational from the address. It clears the flags by writing ones to them. The event inputs take no back-pressure: a strobe can arrive in any cycle, and it is taken at the next rising clock edge.

Top module: `ecc_err_log`

## Requirements
- R1: After reset, every register reads zero and `serr_o` is low.
- R2: A CE strobe sets status bit 0 and a UE strobe sets status bit 7 (register offset 0x00). Each flag stays set until software clears it, and both can be set at once.
- R3: The error address register (offset 0x04) returns the logged block address in bits 31:12, with bits 11:0 zero. The syndrome register (offset 0x08) returns the syndrome in bits 7:0. The channel register (offset 0x0C) returns the channel in bit 0. All other bits of these registers read zero. A CE or UE that arrives when nothing is logged fills these fields.
- R4: A UE that arrives while only a CE is logged overwrites the address, syndrome and channel with its own values. The CE flag stays set.
- R5: A CE that arrives while a CE or a UE is logged leaves the logged fields unchanged. A UE that arrives while a UE is logged also leaves them unchanged.
- R6: If a CE and a UE arrive in the same cycle with nothing logged, the UE's details are logged and both flags are set.
- R7: A write to the status register clears bit 0 if data bit 0 is 1, and clears bit 7 if data bit 7 is 1. Zeros in those data bits, and all other data bits, have no effect.
- R8: If a clear and a new event of the same class land in the same cycle, the flag stays set. If the clear empties the log in that cycle, the new event's details are logged.
- R9: The command register (offset 0x10) stores bit 7 as the CE signalling enable and bit 8 as the UE signalling enable. Its other bits read zero.
- R10: `serr_o` is high exactly while (status bit 0 AND enable bit 7) OR (status bit 7 AND enable bit 8). It follows the registers with no added cycle.
- R11: A write takes effect at the clock edge that samples it. A read of any address other than the five register offsets returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_valid | input | 1 | Correctable-error strobe |
| ce_blk_addr | input | 20 | Failing block address of the CE |
| ce_syndrome | input | 8 | Syndrome of the CE |
| ce_channel | input | 1 | Channel of the CE |
| ue_valid | input | 1 | Uncorrectable-error strobe |
| ue_blk_addr | input | 20 | Failing block address of the UE |
| ue_syndrome | input | 8 | Syndrome of the UE |
| ue_channel | input | 1 | Channel of the UE |
| bus_addr | input | 8 | Register byte offset |
| bus_wen | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| serr_o | output | 1 | System-error output |

## Verification
The bench aims at the priority cases of the log slot:
- A CE arriving after a CE. A design that lets it overwrite the slot would lose the first error's address.
- A UE arriving after a CE. A design that kept the CE's details would report a correctable location for an uncorrectable error.
- A CE and a UE arriving together. A design that chose the CE here would report the wrong location.

It also lands a clear in the same cycle as a new event. A design that let the clear win would drop that event without a trace. The bench then toggles the enables against set flags. This shows whether `serr_o` follows each class's enable or stays stuck on a stale value.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  localparam int NCLS   = 2;
  localparam int CLS_CE = 0;
  localparam int CLS_UE = 1;

  localparam int STAT_CE_BIT = 0;
  localparam int STAT_UE_BIT = 7;
  localparam int CMD_CE_BIT  = 7;
  localparam int CMD_UE_BIT  = 8;

  localparam int OFS_STATUS = 'h00;
  localparam int OFS_ADDR   = 'h04;
  localparam int OFS_SYN    = 'h08;
  localparam int OFS_CHAN   = 'h0C;
  localparam int OFS_CMD    = 'h10;

  function automatic int stat_bit(input int cls);
    return (cls == CLS_CE) ? STAT_CE_BIT : STAT_UE_BIT;
  endfunction

  function automatic int cmd_bit(input int cls);
    return (cls == CLS_CE) ? CMD_CE_BIT : CMD_UE_BIT;
  endfunction
endpackage

// File: rtl/ecc_log_regbus.sv
module ecc_log_regbus
  import ecc_log_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int BLK_W = 20,
  parameter int SYN_W = 8
) (
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wen,
  input  logic [DW-1:0]    bus_wdata,
  input  logic [NCLS-1:0]  flag,
  input  logic [NCLS-1:0]  en,
  input  logic [BLK_W-1:0] log_blk,
  input  logic [SYN_W-1:0] log_syn,
  input  logic             log_ch,
  output logic [NCLS-1:0]  clr_req,
  output logic             wr_cmd,
  output logic [NCLS-1:0]  en_next,
  output logic [DW-1:0]    bus_rdata
);
  localparam int LOW_W = DW - BLK_W;

  logic sel_status, sel_cmd;
  logic wdata_unused;

  assign sel_status   = (bus_addr == AW'(OFS_STATUS));
  assign sel_cmd      = (bus_addr == AW'(OFS_CMD));
  assign wr_cmd       = bus_wen && sel_cmd;
  assign wdata_unused = ^bus_wdata;

  for (genvar c = 0; c < NCLS; c++) begin : g_wr
    assign clr_req[c] = bus_wen && sel_status && bus_wdata[stat_bit(c)];
    assign en_next[c] = bus_wdata[cmd_bit(c)];
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      AW'(OFS_STATUS): begin
        bus_rdata[STAT_CE_BIT] = flag[CLS_CE];
        bus_rdata[STAT_UE_BIT] = flag[CLS_UE];
      end
      AW'(OFS_ADDR):   bus_rdata = {log_blk, {LOW_W{1'b0}}};
      AW'(OFS_SYN):    bus_rdata[SYN_W-1:0] = log_syn;
      AW'(OFS_CHAN):   bus_rdata[0] = log_ch;
      AW'(OFS_CMD): begin
        bus_rdata[CMD_CE_BIT] = en[CLS_CE];
        bus_rdata[CMD_UE_BIT] = en[CLS_UE];
      end
      default:         bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ecc_log_status.sv
module ecc_log_status
  import ecc_log_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCLS-1:0] ev,
  input  logic [NCLS-1:0] clr_req,
  input  logic            wr_cmd,
  input  logic [NCLS-1:0] en_next,
  output logic [NCLS-1:0] flag,
  output logic [NCLS-1:0] held,
  output logic [NCLS-1:0] en,
  output logic            serr
);
  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    logic fl_q, en_q;

    assign held[c] = fl_q & ~clr_req[c];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        fl_q <= 1'b0;
        en_q <= 1'b0;
      end else begin
        fl_q <= held[c] | ev[c];
        if (wr_cmd) en_q <= en_next[c];
      end
    end

    assign flag[c] = fl_q;
    assign en[c]   = en_q;
  end

  assign serr = |(flag & en);
endmodule

// File: rtl/ecc_log_capture.sv
module ecc_log_capture
  import ecc_log_pkg::*;
#(
  parameter int BLK_W = 20,
  parameter int SYN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCLS-1:0]  held,
  input  logic             ce_valid,
  input  logic [BLK_W-1:0] ce_blk,
  input  logic [SYN_W-1:0] ce_syn,
  input  logic             ce_ch,
  input  logic             ue_valid,
  input  logic [BLK_W-1:0] ue_blk,
  input  logic [SYN_W-1:0] ue_syn,
  input  logic             ue_ch,
  output logic [BLK_W-1:0] log_blk,
  output logic [SYN_W-1:0] log_syn,
  output logic             log_ch
);
  logic take_ue, take_ce;

  assign take_ue = ue_valid && !held[CLS_UE];
  assign take_ce = ce_valid && (held == '0) && !take_ue;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      log_blk <= '0;
      log_syn <= '0;
      log_ch  <= 1'b0;
    end else if (take_ue) begin
      log_blk <= ue_blk;
      log_syn <= ue_syn;
      log_ch  <= ue_ch;
    end else if (take_ce) begin
      log_blk <= ce_blk;
      log_syn <= ce_syn;
      log_ch  <= ce_ch;
    end
  end
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
  import ecc_log_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int BLK_W = 20,
  parameter int SYN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_valid,
  input  logic [BLK_W-1:0] ce_blk_addr,
  input  logic [SYN_W-1:0] ce_syndrome,
  input  logic             ce_channel,
  input  logic             ue_valid,
  input  logic [BLK_W-1:0] ue_blk_addr,
  input  logic [SYN_W-1:0] ue_syndrome,
  input  logic             ue_channel,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wen,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic             serr_o
);
  logic [NCLS-1:0]  flag, held, en, clr_req, en_next;
  logic             wr_cmd;
  logic [BLK_W-1:0] log_blk;
  logic [SYN_W-1:0] log_syn;
  logic             log_ch;

  ecc_log_regbus #(.AW(AW), .DW(DW), .BLK_W(BLK_W), .SYN_W(SYN_W)) u_bus (
    .bus_addr(bus_addr), .bus_wen(bus_wen), .bus_wdata(bus_wdata),
    .flag(flag), .en(en), .log_blk(log_blk), .log_syn(log_syn), .log_ch(log_ch),
    .clr_req(clr_req), .wr_cmd(wr_cmd), .en_next(en_next), .bus_rdata(bus_rdata)
  );

  ecc_log_status u_stat (
    .clk(clk), .rst_n(rst_n), .ev({ue_valid, ce_valid}), .clr_req(clr_req),
    .wr_cmd(wr_cmd), .en_next(en_next), .flag(flag), .held(held), .en(en),
    .serr(serr_o)
  );

  ecc_log_capture #(.BLK_W(BLK_W), .SYN_W(SYN_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .held(held),
    .ce_valid(ce_valid), .ce_blk(ce_blk_addr), .ce_syn(ce_syndrome), .ce_ch(ce_channel),
    .ue_valid(ue_valid), .ue_blk(ue_blk_addr), .ue_syn(ue_syndrome), .ue_ch(ue_channel),
    .log_blk(log_blk), .log_syn(log_syn), .log_ch(log_ch)
  );
endmodule

// File: rtl/ecc_err_log_chk.sv
module ecc_err_log_chk
  import ecc_log_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int BLK_W = 20,
  parameter int SYN_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ce_valid,
  input logic             ue_valid,
  input logic [BLK_W-1:0] ue_blk_addr,
  input logic [SYN_W-1:0] ue_syndrome,
  input logic [AW-1:0]    bus_addr,
  input logic             bus_wen,
  input logic [DW-1:0]    bus_wdata,
  input logic [DW-1:0]    bus_rdata,
  input logic             serr_o,
  input logic [NCLS-1:0]  flag,
  input logic [NCLS-1:0]  held,
  input logic [BLK_W-1:0] log_blk,
  input logic [SYN_W-1:0] log_syn,
  input logic             log_ch
);
  localparam int LOW_W = DW - BLK_W;

  p_ce_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ce_valid |=> flag[CLS_CE]);

  p_ue_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ue_valid |=> flag[CLS_UE]);

  p_addr_low_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == AW'(OFS_ADDR)) |-> (bus_rdata[LOW_W-1:0] == '0));

  p_ue_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ue_valid && !held[CLS_UE]) |=>
      (log_blk == $past(ue_blk_addr)) && (log_syn == $past(ue_syndrome)));

  p_ce_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_valid && !ue_valid && (held != '0)) |=>
      ($stable(log_blk) && $stable(log_syn) && $stable(log_ch)));

  p_w1c_ce_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wen && bus_addr == AW'(OFS_STATUS) && bus_wdata[STAT_CE_BIT] && !ce_valid)
      |=> !flag[CLS_CE]);

  p_serr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (serr_o && !bus_wen) |=> serr_o);
endmodule

bind ecc_err_log ecc_err_log_chk #(.AW(AW), .DW(DW), .BLK_W(BLK_W), .SYN_W(SYN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_valid(ce_valid), .ue_valid(ue_valid),
  .ue_blk_addr(ue_blk_addr), .ue_syndrome(ue_syndrome),
  .bus_addr(bus_addr), .bus_wen(bus_wen), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .serr_o(serr_o), .flag(flag), .held(held),
  .log_blk(log_blk), .log_syn(log_syn), .log_ch(log_ch)
);

// File: tb/tb_ecc_err_log.sv
module tb_ecc_err_log;
  localparam logic [7:0] A_STAT = 8'h00, A_ADDR = 8'h04, A_SYN = 8'h08,
                         A_CHAN = 8'h0C, A_CMD = 8'h10, A_NONE1 = 8'h14, A_NONE2 = 8'h01;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_valid = 0, ue_valid = 0, ce_channel = 0, ue_channel = 0, bus_wen = 0;
  logic [19:0] ce_blk_addr = 0, ue_blk_addr = 0;
  logic [7:0]  ce_syndrome = 0, ue_syndrome = 0, bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic serr_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [1:0]  e_flag = 0, e_en = 0;
  logic [19:0] e_blk = 0;
  logic [7:0]  e_syn = 0;
  logic        e_ch = 0;

  always #10 clk = ~clk;

  ecc_err_log dut (
    .clk(clk), .rst_n(rst_n),
    .ce_valid(ce_valid), .ce_blk_addr(ce_blk_addr), .ce_syndrome(ce_syndrome), .ce_channel(ce_channel),
    .ue_valid(ue_valid), .ue_blk_addr(ue_blk_addr), .ue_syndrome(ue_syndrome), .ue_channel(ue_channel),
    .bus_addr(bus_addr), .bus_wen(bus_wen), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .serr_o(serr_o)
  );

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    logic [31:0] r = '0;
    case (a)
      A_STAT: begin r[0] = e_flag[0]; r[7] = e_flag[1]; end
      A_ADDR: r = {e_blk, 12'h000};
      A_SYN:  r[7:0] = e_syn;
      A_CHAN: r[0] = e_ch;
      A_CMD:  begin r[7] = e_en[0]; r[8] = e_en[1]; end
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string req_of(input logic [7:0] a);
    case (a)
      A_STAT: return "R2";
      A_ADDR, A_SYN, A_CHAN: return "R3";
      A_CMD:  return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic cmp(input string ctx, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s/%s actual=%h expected=%h", ctx, tag, act, exp);
    end
  endtask

  task automatic check_regs(input string ctx);
    logic [7:0] lst [7] = '{A_STAT, A_ADDR, A_SYN, A_CHAN, A_CMD, A_NONE1, A_NONE2};
    for (int i = 0; i < 7; i++) begin
      bus_addr = lst[i];
      #1;
      cmp(ctx, req_of(lst[i]), bus_rdata, exp_read(lst[i]));
    end
    cmp(ctx, "R10 serr", {31'b0, serr_o},
        {31'b0, (e_flag[0] & e_en[0]) | (e_flag[1] & e_en[1])});
  endtask

  task automatic step(input string ctx,
                      input logic cv, input logic [19:0] cb, input logic [7:0] cs, input logic cc,
                      input logic uv, input logic [19:0] ub, input logic [7:0] us, input logic uc,
                      input logic we, input logic [7:0] wa, input logic [31:0] wd);
    logic [1:0] clr, hld, n_flag, n_en;
    logic [19:0] n_blk;
    logic [7:0] n_syn;
    logic n_ch;
    @(negedge clk);
    ce_valid = cv; ce_blk_addr = cb; ce_syndrome = cs; ce_channel = cc;
    ue_valid = uv; ue_blk_addr = ub; ue_syndrome = us; ue_channel = uc;
    bus_wen = we; bus_addr = wa; bus_wdata = wd;
    clr = (we && wa == A_STAT) ? {wd[7], wd[0]} : 2'b00;
    hld = e_flag & ~clr;
    n_blk = e_blk; n_syn = e_syn; n_ch = e_ch;
    if (uv && !hld[1]) begin n_blk = ub; n_syn = us; n_ch = uc; end
    else if (cv && hld == 2'b00) begin n_blk = cb; n_syn = cs; n_ch = cc; end
    n_flag = hld | {uv, cv};
    n_en = (we && wa == A_CMD) ? {wd[8], wd[7]} : e_en;
    @(posedge clk);
    #1;
    ce_valid = 0; ue_valid = 0; bus_wen = 0;
    e_flag = n_flag; e_en = n_en; e_blk = n_blk; e_syn = n_syn; e_ch = n_ch;
    check_regs(ctx);
  endtask

  task automatic ev(input string ctx, input logic cv, input logic [19:0] cb, input logic [7:0] cs,
                    input logic cc, input logic uv, input logic [19:0] ub, input logic [7:0] us,
                    input logic uc);
    step(ctx, cv, cb, cs, cc, uv, ub, us, uc, 1'b0, A_NONE1, 32'h0);
  endtask

  task automatic wr(input string ctx, input logic [7:0] a, input logic [31:0] d);
    step(ctx, 1'b0, 20'h0, 8'h0, 1'b0, 1'b0, 20'h0, 8'h0, 1'b0, 1'b1, a, d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog all-R actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check_regs("R1");

    ev("R3", 1, 20'hABCDE, 8'h5A, 1, 0, 20'h0, 8'h0, 0);
    ev("R5", 1, 20'h11111, 8'h22, 0, 0, 20'h0, 8'h0, 0);
    ev("R4", 0, 20'h0, 8'h0, 0, 1, 20'hFEDCB, 8'hC3, 0);
    ev("R5", 0, 20'h0, 8'h0, 0, 1, 20'h33333, 8'h44, 1);
    ev("R5", 1, 20'h55555, 8'h66, 1, 0, 20'h0, 8'h0, 0);
    wr("R7", A_STAT, 32'h0000_0000);
    wr("R7", A_STAT, 32'hFFFF_FF7E);
    wr("R7", A_STAT, 32'h0000_0001);
    wr("R7", A_STAT, 32'h0000_0080);
    ev("R6", 1, 20'h0AAAA, 8'h01, 0, 1, 20'h0BBBB, 8'h02, 1);
    step("R8", 1, 20'h0CCCC, 8'h03, 1, 0, 20'h0, 8'h0, 0, 1, A_STAT, 32'h0000_0081);
    step("R8", 0, 20'h0, 8'h0, 0, 1, 20'h0DDDD, 8'h04, 0, 1, A_STAT, 32'h0000_0080);
    wr("R9", A_CMD, 32'hFFFF_FFFF);
    wr("R10", A_STAT, 32'h0000_0001);
    wr("R10", A_CMD, 32'h0000_0080);
    ev("R10", 1, 20'h0EEEE, 8'h05, 0, 0, 20'h0, 8'h0, 0);
    wr("R10", A_CMD, 32'h0000_0000);
    wr("R11", A_NONE1, 32'hFFFF_FFFF);

    for (int i = 0; i < 3000; i++) begin
      logic cv, uv, we;
      logic [7:0] wa;
      cv = ($urandom % 4) == 0;
      uv = ($urandom % 8) == 0;
      we = ($urandom % 4) == 0;
      wa = ($urandom % 2) ? A_STAT : A_CMD;
      step("rand", cv, 20'($urandom), 8'($urandom), 1'($urandom), uv, 20'($urandom),
           8'($urandom), 1'($urandom), we, wa, $urandom);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule